// File: doc/BRIEF.md
# Dual-channel PWM slice

This block is one PWM slice. A single counter feeds two compare channels, A and B, and each channel drives one output. The counter does not step on every clock. It steps on a clock enable made by a fractional divider, which has 8 integer bits and 4 fractional bits.

The counter has two modes:
- **Trailing-edge mode:** the counter climbs to the top value and then returns to zero.
- **Phase-correct mode:** the counter climbs to the top value and then descends back to zero. This doubles the period and keeps each pulse centred.

A small write-only register port sets up the slice. While the slice is running, two single-cycle request inputs shift the output phase by one count:
- **Advance** inserts an extra enable pulse.
- **Retard** deletes one enable pulse.

Each request shows a busy flag until it has been applied. The current counter value and a one-cycle wrap pulse are available as outputs.

Register map, written with `cfgWe`, `cfgAddr` and `cfgData`:

| Address | Contents |
|---|---|
| 0 | Control: bit0 run, bit1 phase-correct, bit2 invert A, bit3 invert B |
| 1 | Divider in 8.4 fixed point, bits [11:0] |
| 2 | Top value |
| 3 | Compare A |
| 4 | Compare B |

Reset values are: control 0, divider 0x010 (1.0), top 0xFFFF, both compares 0.

Top module: `pwm_slice`

## Requirements
- R1: In trailing-edge mode, each enable tick advances the counter by one. The tick taken at a count at or above top returns it to 0. A period is (top+1) ticks.
- R2: In phase-correct mode, the counter climbs to top and holds there for one extra tick. It then descends to 0 and holds there for one tick, and that tick is the wrap. A period is 2*(top+1) ticks, and any duty cycle gives a pulse centred on the wrap.
- R3: An output, before inversion, is high exactly while its compare value is greater than the counter. A compare of 0 is always low, and a compare of top+1 is high for the whole period.
- R4: Control bits 2 and 3 invert outputs A and B after the compare. The inversion takes effect on the cycle after the write.
- R5: With divider value D in 8.4 fixed point, ticks arrive on average once every D/16 clocks. A remainder accumulator carries the fraction. D=0x010 ticks on every clock. An integer part of 0 counts as 256.
- R6: A request on `advReq` while running sets `advBusy`. One tick is then inserted on the first clock that has no natural tick, and `advBusy` clears. The counter never moves more than one step per clock, so at divider 1.0 the request stays pending.
- R7: A request on `retReq` while running sets `retBusy`. The next natural tick is then swallowed and `retBusy` clears.
- R8: While the run bit (control bit 0) is 0:
  - the counter holds its value;
  - the divider remainder is cleared;
  - both busy flags clear;
  - phase requests are ignored.
- R9: Top and compare values written while running take effect only at the tick that wraps the counter. While stopped, they take effect on the next clock.
- R10: `wrap` is high for one clock after each wrapping tick, and the counter reads 0 while it is high.
- R11: Writes to addresses other than 0 to 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | ADDR_W | Register address |
| cfgData | input | 16 | Register write data |
| advReq | input | 1 | Phase-advance request pulse |
| retReq | input | 1 | Phase-retard request pulse |
| count | output | 16 | Counter value |
| wrap | output | 1 | One-cycle pulse after a wrap |
| outA | output | 1 | Channel A output |
| outB | output | 1 | Channel B output |
| advBusy | output | 1 | Advance request pending |
| retBusy | output | 1 | Retard request pending |

## Verification
The bound checker watches five properties on every cycle:
- the counter moves by at most one step, or returns to zero;
- the counter reads zero during the wrap pulse;
- a stopped slice freezes the counter;
- a stopped slice clears both busy flags;
- advance requests register only while the slice runs.

The bench's scenarios are needed for the rest:
- period lengths for integer, fractional and zero-integer divider settings;
- phase-correct period doubling and pulse centring;
- the exact number of cycles that an advance removes from a period and a retard adds to it;
- deferred compare updates;
- ignored writes.

A behavioural model in the bench compares every output on each clock throughout.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;
  parameter int CNT_W  = 16;
  parameter int DIV_W  = 12;
  parameter int FRAC_W = 4;

  typedef struct packed {
    logic             en;
    logic             pc;
    logic             invA;
    logic             invB;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] top;
    logic [CNT_W-1:0] cmpA;
    logic [CNT_W-1:0] cmpB;
  } cfg_t;

  typedef struct packed {
    logic tick;
    logic run;
  } strobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_slice_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgData,
  input  logic              advReq,
  input  logic              retReq,
  output cfg_t              cfgQ,
  output strobe_t           strb,
  output logic              advBusy,
  output logic              retBusy
);
  localparam int ACC_W = DIV_W + 1;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_W;
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1) << FRAC_W;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] divVal;
  logic [ACC_W-1:0] accNext;
  logic             natTick;
  logic             unusedBits;

  assign unusedBits = ^cfgData[CNT_W-1:DIV_W];

  // integer part of zero stands for 256
  assign divVal  = {(cfgQ.div[DIV_W-1:FRAC_W] == '0), cfgQ.div};
  assign accNext = acc + STEP;
  assign natTick = cfgQ.en && (accNext >= divVal);

  assign strb.run  = cfgQ.en;
  assign strb.tick = cfgQ.en && ((natTick && !retBusy) || (!natTick && advBusy));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ    <= '{en: 1'b0, pc: 1'b0, invA: 1'b0, invB: 1'b0,
                   div: DIV_ONE, top: '1, cmpA: '0, cmpB: '0};
      acc     <= '0;
      advBusy <= 1'b0;
      retBusy <= 1'b0;
    end else begin
      if (!cfgQ.en)     acc <= '0;
      else if (natTick) acc <= accNext - divVal;
      else              acc <= accNext;

      advBusy <= cfgQ.en && ((advBusy && natTick) || advReq);
      retBusy <= cfgQ.en && ((retBusy && !natTick) || retReq);

      if (cfgWe) begin
        case (cfgAddr)
          ADDR_W'(0): begin
            cfgQ.en   <= cfgData[0];
            cfgQ.pc   <= cfgData[1];
            cfgQ.invA <= cfgData[2];
            cfgQ.invB <= cfgData[3];
          end
          ADDR_W'(1): cfgQ.div  <= cfgData[DIV_W-1:0];
          ADDR_W'(2): cfgQ.top  <= cfgData;
          ADDR_W'(3): cfgQ.cmpA <= cfgData;
          ADDR_W'(4): cfgQ.cmpB <= cfgData;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_dp.sv
module pwm_dp
  import pwm_slice_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfgQ,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             outA,
  output logic             outB
);
  logic [CNT_W-1:0] actTop;
  logic [CNT_W-1:0] actCmpA;
  logic [CNT_W-1:0] actCmpB;
  logic             dirDown;
  logic             atEnd;
  logic             wrapNow;
  logic             unusedDp;

  assign unusedDp = ^{cfgQ.div, cfgQ.en};

  assign atEnd   = (count >= actTop);
  assign wrapNow = strb.tick && (cfgQ.pc ? (dirDown && count == '0) : atEnd);

  assign outA = (actCmpA > count) ^ cfgQ.invA;
  assign outB = (actCmpB > count) ^ cfgQ.invB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      dirDown <= 1'b0;
      wrap    <= 1'b0;
      actTop  <= '1;
      actCmpA <= '0;
      actCmpB <= '0;
    end else begin
      wrap <= wrapNow;
      if (!cfgQ.pc) dirDown <= 1'b0;
      if (strb.tick) begin
        if (cfgQ.pc) begin
          if (!dirDown) begin
            if (atEnd) dirDown <= 1'b1;
            else       count   <= count + 1'b1;
          end else begin
            if (count == '0) dirDown <= 1'b0;
            else             count   <= count - 1'b1;
          end
        end else begin
          count <= atEnd ? '0 : count + 1'b1;
        end
      end
      if (!strb.run || wrapNow) begin
        actTop  <= cfgQ.top;
        actCmpA <= cfgQ.cmpA;
        actCmpB <= cfgQ.cmpB;
      end
    end
  end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_slice_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgData,
  input  logic              advReq,
  input  logic              retReq,
  output logic [CNT_W-1:0]  count,
  output logic              wrap,
  output logic              outA,
  output logic              outB,
  output logic              advBusy,
  output logic              retBusy
);
  cfg_t    cfgQ;
  strobe_t strb;

  pwm_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .advReq(advReq), .retReq(retReq), .cfgQ(cfgQ), .strb(strb),
    .advBusy(advBusy), .retBusy(retBusy)
  );

  pwm_dp dp_i (
    .clk(clk), .rstN(rstN), .cfgQ(cfgQ), .strb(strb),
    .count(count), .wrap(wrap), .outA(outA), .outB(outB)
  );
endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk
  import pwm_slice_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] count,
  input logic             wrap,
  input logic             advBusy,
  input logic             retBusy,
  input logic             enQ
);
  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |->
      (count == $past(count) + 1'b1 || count == $past(count) - 1'b1 || count == '0));

  // R10
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrap |-> (count == '0));

  // R8
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |=> $stable(count));

  // R8
  busy_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |=> (!advBusy && !retBusy));

  // R6
  adv_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(advBusy) |-> $past(enQ));
endmodule

bind pwm_slice pwm_slice_chk chk_i (
  .clk(clk), .rstN(rstN), .count(count), .wrap(wrap),
  .advBusy(advBusy), .retBusy(retBusy), .enQ(cfgQ.en)
);

// File: tb/pwm_slice_tb.sv
module pwm_slice_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic        advReq = 1'b0;
  logic        retReq = 1'b0;
  logic [15:0] count;
  logic        wrap, outA, outB, advBusy, retBusy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_slice dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .advReq(advReq), .retReq(retReq), .count(count), .wrap(wrap),
    .outA(outA), .outB(outB), .advBusy(advBusy), .retBusy(retBusy)
  );

  // behavioural reference model
  int mEn, mPc, mInvA, mInvB, mDiv, mTop, mCa, mCb;
  int sTop, sCa, sCb, mAcc, mCnt, mDown, mWrap, mAdv, mRet;

  function automatic int divUnits(int d);
    return ((d >> 4) == 0) ? (4096 + (d & 15)) : d;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mPc = 0; mInvA = 0; mInvB = 0; mDiv = 16; mTop = 65535; mCa = 0; mCb = 0;
      sTop = 65535; sCa = 0; sCb = 0; mAcc = 0; mCnt = 0; mDown = 0; mWrap = 0; mAdv = 0; mRet = 0;
    end else begin
      int nat, tk, wr, dv;
      dv  = divUnits(mDiv);
      nat = (mEn != 0) && (mAcc + 16 >= dv);
      tk  = (mEn != 0) && ((nat && !mRet) || (!nat && mAdv));
      wr  = 0;
      if (tk) begin
        if (mPc) begin
          if (!mDown) begin
            if (mCnt >= sTop) mDown = 1; else mCnt++;
          end else begin
            if (mCnt == 0) begin mDown = 0; wr = 1; end else mCnt--;
          end
        end else begin
          if (mCnt >= sTop) begin mCnt = 0; wr = 1; end else mCnt++;
        end
      end
      if (!mPc) mDown = 0;
      if (!mEn || wr) begin sTop = mTop; sCa = mCa; sCb = mCb; end
      mWrap = wr;
      if (!mEn) mAcc = 0; else if (nat) mAcc = mAcc + 16 - dv; else mAcc = mAcc + 16;
      mAdv = (mEn != 0) && ((mAdv && nat) || advReq);
      mRet = (mEn != 0) && ((mRet && !nat) || retReq);
      if (cfgWe) begin
        case (cfgAddr)
          3'd0: begin mEn = cfgData[0]; mPc = cfgData[1]; mInvA = cfgData[2]; mInvB = cfgData[3]; end
          3'd1: mDiv = cfgData & 16'h0FFF;
          3'd2: mTop = cfgData;
          3'd3: mCa = cfgData;
          3'd4: mCb = cfgData;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      int eA, eB;
      eA = (sCa > mCnt) ^ mInvA;
      eB = (sCb > mCnt) ^ mInvB;
      chk(int'(count) == mCnt, "R1 R2 count vs model", count, mCnt);
      chk(int'(outA) == eA, "R3 R4 outA vs model", outA, eA);
      chk(int'(outB) == eB, "R3 R4 outB vs model", outB, eB);
      chk(int'(wrap) == mWrap, "R10 wrap vs model", wrap, mWrap);
      chk(int'(advBusy) == mAdv, "R6 advBusy vs model", advBusy, mAdv);
      chk(int'(retBusy) == mRet, "R7 retBusy vs model", retBusy, mRet);
    end
  end

  task automatic wr(input int a, input int d);
    cfgWe = 1; cfgAddr = 3'(a); cfgData = 16'(d);
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic waitWrap();
    do @(negedge clk); while (!wrap);
  endtask

  task automatic measureRest(output int n, output int hA, output int hB);
    n = 0; hA = 0; hB = 0;
    do begin
      hA += outA; hB += outB;
      @(negedge clk);
      advReq = 0; retReq = 0;
      n++;
    end while (!wrap);
  endtask

  task automatic measure(output int n, output int hA, output int hB);
    waitWrap();
    measureRest(n, hA, hB);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, hA, hB, c0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8 reset state: stopped, zero outputs
    chk(count == 0 && wrap == 0 && outA == 0 && outB == 0, "R8 reset state", count, 0);

    // R1 R5: top 4, divider 2.0, compare A 2
    wr(2, 4); wr(1, 16'h020); wr(3, 2); wr(4, 0); wr(0, 1);
    measure(n, hA, hB); measure(n, hA, hB);
    chk(n == 10, "R1 R5 period top4 div2.0", n, 10);
    chk(hA == 4, "R3 high cycles cmp2", hA, 4);
    chk(hB == 0, "R3 cmp0 always low", hB, 0);

    // R3 compare top+1 always high; R4 invert B
    wr(3, 5); wr(0, 16'h9);
    measure(n, hA, hB); measure(n, hA, hB);
    chk(hA == 10, "R3 cmp top+1 always high", hA, 10);
    chk(hB == 10, "R4 invert B of cmp0", hB, 10);

    // R9 compare change mid-period waits for wrap
    waitWrap(); repeat (3) @(negedge clk);
    wr(3, 0); @(negedge clk);
    chk(outA == 1, "R9 compare deferred to wrap", outA, 1);
    measure(n, hA, hB);
    chk(hA == 0, "R9 compare applied after wrap", hA, 0);

    // R5 fractional 1.5, top 3
    wr(0, 1); wr(2, 3); wr(1, 16'h018);
    measure(n, hA, hB); measure(n, hA, hB);
    chk(n == 6, "R5 fractional divider 1.5", n, 6);

    // R5 integer part zero counts as 256, top 0
    wr(2, 0); wr(1, 16'h000);
    measure(n, hA, hB); measure(n, hA, hB);
    chk(n == 256, "R5 divider int zero as 256", n, 256);

    // R2 phase-correct, top 4, div 2.0, cmp A 2
    wr(1, 16'h020); wr(2, 4); wr(3, 2); wr(0, 16'h3);
    measure(n, hA, hB); measure(n, hA, hB);
    chk(n == 20, "R2 phase-correct period", n, 20);
    chk(hA == 8, "R2 phase-correct duty", hA, 8);

    // R6 advance in trailing-edge mode
    wr(0, 1);
    measure(n, hA, hB); measure(n, hA, hB);
    waitWrap(); advReq = 1;
    measureRest(n, hA, hB);
    chk(n == 8, "R6 advance shortens period", n, 8);
    measure(n, hA, hB);
    chk(n == 10, "R6 period restored after advance", n, 10);

    // R7 retard
    waitWrap(); retReq = 1;
    measureRest(n, hA, hB);
    chk(n == 12, "R7 retard lengthens period", n, 12);
    chk(retBusy == 0, "R7 retard busy cleared", retBusy, 0);

    // R6 advance at divider 1.0 stays pending
    wr(1, 16'h010);
    measure(n, hA, hB);
    waitWrap(); advReq = 1;
    measureRest(n, hA, hB);
    chk(n == 5, "R6 no double step at div1.0", n, 5);
    chk(advBusy == 1, "R6 advance stays pending", advBusy, 1);

    // R8 stop: counter holds, busy cleared, requests ignored
    repeat (2) @(negedge clk);
    wr(0, 0); @(negedge clk);
    chk(advBusy == 0, "R8 busy cleared when stopped", advBusy, 0);
    c0 = count;
    retReq = 1; advReq = 1; @(negedge clk); retReq = 0; advReq = 0;
    repeat (10) @(negedge clk);
    chk(int'(count) == c0, "R8 counter holds when stopped", count, c0);
    chk(retBusy == 0 && advBusy == 0, "R8 requests ignored when stopped", retBusy, 0);

    // R11 write to unmapped address
    wr(2, 4); wr(1, 16'h020); wr(0, 1);
    wr(7, 16'hFFFF); wr(5, 0);
    measure(n, hA, hB); measure(n, hA, hB);
    chk(n == 10, "R11 unmapped writes ignored", n, 10);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule